// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block holds the internal word address of a small serial byte memory and advances it after every byte moved. A protocol engine (outside this block) pulses a load strobe when it has received a word-address byte, presenting that byte together with the page-select bits it took from the device-select byte. It pulses an increment strobe after each data byte, with a mode flag that says whether the transfer was a read or a write. The array itself is outside this block too; it simply uses the current address output.

Writes advance only the in-page offset, so a burst longer than a page wraps back to the start of the same page and overwrites earlier bytes. Reads advance the whole address and roll from the last location of the array to location zero. The value survives between transactions, so a later current-address read starts one past the last location touched. The array size is a build-time parameter `SIZE_SEL` (0..4 for 1K, 2K, 4K, 8K, 16K bits of storage). It sets the address width (7 + `SIZE_SEL`), the page size (8 bytes for sizes 0 and 1, 16 bytes otherwise) and how many page-select bits are used (0, 0, 1, 2, 3).

Top module: `wordaddr_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cur_addr` is zero after that edge.
- R2: A load strobe sets `cur_addr` at the next edge. Its low bits are `load_byte`, and the bits above bit 7 are the low `SIZE_SEL-1` bits of `load_page` (sizes 2..4). The width is `SIZE_SEL+7` bits.
- R3: On a load, bits of `load_page` beyond those the size uses have no effect. For size 0, bit 7 of `load_byte` also has no effect.
- R4: A write-mode increment (`rd_mode`=0) adds one to the low 3 bits (sizes 0,1) or low 4 bits (sizes 2..4) modulo the page size, and leaves all higher bits unchanged.
- R5: A read-mode increment (`rd_mode`=1) adds one to the whole address modulo 2^(`SIZE_SEL`+7), so the last location rolls to zero.
- R6: With neither strobe asserted, `cur_addr` holds its value.
- R7: When load and increment strobes are both high in the same cycle, the load wins and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Load strobe for a newly received word address |
| load_page | input | 3 | Page-select bits from the device-select byte |
| load_byte | input | 8 | Received word-address byte |
| step_en | input | 1 | Increment strobe, one per byte transferred |
| rd_mode | input | 1 | 1 = read transfer, 0 = write transfer |
| cur_addr | output | SIZE_SEL+7 | Current word address |

## Verification
The bench runs a 4K-size and a 1K-size instance side by side. It goes after the top-of-page write wrap, where a design that carried into the page bits would move the burst onto the next page. It also targets the last-location read rollover, which a design that wrapped inside the page would get wrong by jumping back to the page start. On a load it drives set unused page bits and a set top address bit into the small size; a design that kept them would show an address outside the array. The same-cycle load and increment case exposes a wrong priority as an address one past the loaded value.

// File: rtl/wac_pkg.sv
// Package: size-derived geometry for the word address counter.
// Assumes a size selector in the range 0..4 (1K..16K bits of storage).
package wac_pkg;

    localparam int BYTE_W = 8;
    localparam int PAGE_SEL_W = 3;

    // Address width in bits for a size selector.
    function automatic int addr_width(input int sel);
        return 7 + sel;
    endfunction

    // Number of in-page offset bits for a size selector.
    function automatic int page_bits(input int sel);
        return (sel < 2) ? 3 : 4;
    endfunction

    // Number of page-select bits taken from the device-select byte.
    function automatic int sel_bits(input int sel);
        return (sel < 2) ? 0 : sel - 1;
    endfunction

endpackage

// File: rtl/wac_load_compose.sv
// Module: builds the full word address from page-select bits and the
// received address byte. Assumes AW = 7 + SIZE_SEL and that unused
// page bits (and byte bit 7 for the smallest size) are don't-care.
module wac_load_compose #(
    parameter int SIZE_SEL = 2
) (
    input  logic [wac_pkg::PAGE_SEL_W-1:0] load_page,
    input  logic [wac_pkg::BYTE_W-1:0]     load_byte,
    output logic [SIZE_SEL+6:0]            load_addr
);
    localparam int AW  = wac_pkg::addr_width(SIZE_SEL);
    localparam int SB  = wac_pkg::sel_bits(SIZE_SEL);

    generate
        if (SB == 0) begin : g_no_page
            // Address comes from the byte alone; the page field is unused.
            logic [wac_pkg::PAGE_SEL_W-1:0] unused_page;
            assign unused_page = load_page;
            if (AW < wac_pkg::BYTE_W) begin : g_trunc
                logic unused_top;
                assign unused_top = load_byte[wac_pkg::BYTE_W-1];
                assign load_addr  = load_byte[AW-1:0];
            end else begin : g_full
                assign load_addr = load_byte;
            end
        end else if (SB < wac_pkg::PAGE_SEL_W) begin : g_part_page
            // Only the low SB page bits form the address top.
            logic [wac_pkg::PAGE_SEL_W-SB-1:0] unused_page_hi;
            assign unused_page_hi = load_page[wac_pkg::PAGE_SEL_W-1:SB];
            assign load_addr = {load_page[SB-1:0], load_byte};
        end else begin : g_all_page
            // Every page bit is part of the address.
            assign load_addr = {load_page, load_byte};
        end
    endgenerate
endmodule

// File: rtl/wac_step_unit.sv
// Module: computes the incremented address for both transfer kinds.
// Writes wrap inside the current page, reads wrap over the whole array.
// Assumes PB < AW.
module wac_step_unit #(
    parameter int SIZE_SEL = 2
) (
    input  logic [SIZE_SEL+6:0] cur,
    input  logic                rd_mode,
    output logic [SIZE_SEL+6:0] next
);
    localparam int AW = wac_pkg::addr_width(SIZE_SEL);
    localparam int PB = wac_pkg::page_bits(SIZE_SEL);

    logic [PB-1:0] offset_inc;
    logic [AW-1:0] wr_next;
    logic [AW-1:0] rd_next;

    // In-page offset plus one; the carry out is dropped on purpose.
    always_comb begin
        offset_inc = cur[PB-1:0] + 1'b1;
    end

    // Write candidate keeps the page row, read candidate spans the array.
    always_comb begin
        wr_next = {cur[AW-1:PB], offset_inc};
        rd_next = cur + 1'b1;
    end

    // Pick the candidate matching the transfer kind.
    always_comb begin
        next = rd_mode ? rd_next : wr_next;
    end
endmodule

// File: rtl/wac_addr_reg.sv
// Module: the address register with load-over-increment priority.
// Assumes synchronous active-low reset to zero.
module wac_addr_reg #(
    parameter int SIZE_SEL = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [SIZE_SEL+6:0] load_addr,
    input  logic                step_en,
    input  logic [SIZE_SEL+6:0] step_addr,
    output logic [SIZE_SEL+6:0] q
);
    // Holds the address; load beats increment, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= load_addr;
        end else if (step_en) begin
            q <= step_addr;
        end
    end
endmodule

// File: rtl/wordaddr_counter.sv
// Module: page-wrapping word address counter for a serial byte memory.
// Loads from page bits plus an address byte, then steps once per byte:
// in-page wrap for writes, whole-array wrap for reads. The value persists
// between transactions. Assumes SIZE_SEL in 0..4.
module wordaddr_counter #(
    parameter int SIZE_SEL = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_en,
    input  logic [wac_pkg::PAGE_SEL_W-1:0] load_page,
    input  logic [wac_pkg::BYTE_W-1:0]     load_byte,
    input  logic                           step_en,
    input  logic                           rd_mode,
    output logic [SIZE_SEL+6:0]            cur_addr
);
    logic [SIZE_SEL+6:0] load_addr;
    logic [SIZE_SEL+6:0] step_addr;

    wac_load_compose #(.SIZE_SEL(SIZE_SEL)) u_compose (
        .load_page (load_page),
        .load_byte (load_byte),
        .load_addr (load_addr)
    );

    wac_step_unit #(.SIZE_SEL(SIZE_SEL)) u_step (
        .cur     (cur_addr),
        .rd_mode (rd_mode),
        .next    (step_addr)
    );

    wac_addr_reg #(.SIZE_SEL(SIZE_SEL)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .step_en   (step_en),
        .step_addr (step_addr),
        .q         (cur_addr)
    );
endmodule

// File: rtl/wac_checker.sv
// Module: assertion checker for wordaddr_counter, attached by bind.
module wac_checker #(
    parameter int SIZE_SEL = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           load_en,
    input logic [wac_pkg::BYTE_W-1:0]     load_byte,
    input logic                           step_en,
    input logic                           rd_mode,
    input logic [SIZE_SEL+6:0]            cur_addr
);
    localparam int AW = wac_pkg::addr_width(SIZE_SEL);
    localparam int PB = wac_pkg::page_bits(SIZE_SEL);
    localparam int LB = (AW < wac_pkg::BYTE_W) ? AW : wac_pkg::BYTE_W;

    logic seen_edge = 1'b0;
    logic prev_rst_n = 1'b1;

    // Track whether a previous edge exists and what reset was then.
    always_ff @(posedge clk) begin
        seen_edge  <= 1'b1;
        prev_rst_n <= rst_n;
    end

    // R1: after a reset edge the address is zero.
    always @(posedge clk) begin
        if (seen_edge && !prev_rst_n) begin
            a_r1_reset_zero: assert (cur_addr == '0)
                else $error("a_r1_reset_zero");
        end
    end

    // R2, R7: a load puts the address byte into the low bits, even with a step.
    a_r2_load_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cur_addr[LB-1:0] == $past(load_byte[LB-1:0]));

    // R4: write increments keep the page row.
    a_r4_write_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !rd_mode) |=> cur_addr[AW-1:PB] == $past(cur_addr[AW-1:PB]));

    // R4: write increments advance the in-page offset modulo the page.
    a_r4_write_offset_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !rd_mode) |=>
            cur_addr[PB-1:0] == PB'($past(cur_addr[PB-1:0]) + 1'b1));

    // R5: read increments advance the whole address.
    a_r5_read_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && rd_mode) |=> cur_addr == AW'($past(cur_addr) + 1'b1));

    // R6: no strobe, no change.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(cur_addr));
endmodule

bind wordaddr_counter wac_checker #(.SIZE_SEL(SIZE_SEL)) u_wac_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_byte (load_byte),
    .step_en   (step_en),
    .rd_mode   (rd_mode),
    .cur_addr  (cur_addr)
);

// File: tb/wordaddr_counter_bench.sv
module wordaddr_counter_bench;
    localparam int BIG_SEL = 2;
    localparam int SMALL_SEL = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_en = 1'b0;
    logic [2:0] load_page = '0;
    logic [7:0] load_byte = '0;
    logic step_en = 1'b0;
    logic rd_mode = 1'b0;
    logic [BIG_SEL+6:0] addr_big;
    logic [SMALL_SEL+6:0] addr_small;

    int checks = 0;
    int errors = 0;
    int exp_big = 0;
    int exp_small = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wordaddr_counter #(.SIZE_SEL(BIG_SEL)) u_wordaddr_counter (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_page(load_page),
        .load_byte(load_byte), .step_en(step_en), .rd_mode(rd_mode),
        .cur_addr(addr_big)
    );

    wordaddr_counter #(.SIZE_SEL(SMALL_SEL)) u_wordaddr_counter_small (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_page(load_page),
        .load_byte(load_byte), .step_en(step_en), .rd_mode(rd_mode),
        .cur_addr(addr_small)
    );

    // Reference next address computed from the requirements.
    function automatic int ref_next(input int sel, input int cur, input bit rst,
                                    input bit ld, input int page, input int byt,
                                    input bit st, input bit rd);
        int aw = 7 + sel;
        int pb = (sel < 2) ? 3 : 4;
        int sb = (sel < 2) ? 0 : sel - 1;
        int amask = (1 << aw) - 1;
        int pmask = (1 << pb) - 1;
        if (!rst) return 0;
        if (ld) return ((((page & ((1 << sb) - 1)) << 8) | byt) & amask);
        if (st && rd) return (cur + 1) & amask;
        if (st) return (cur & ~pmask & amask) | ((cur + 1) & pmask);
        return cur;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (int'(addr_big) != exp_big) begin
            errors++;
            $display("FAIL %s size4K: actual=%0h expected=%0h", tag, addr_big, exp_big);
        end
        checks++;
        if (int'(addr_small) != exp_small) begin
            errors++;
            $display("FAIL %s size1K: actual=%0h expected=%0h", tag, addr_small, exp_small);
        end
    endtask

    // Apply one cycle of stimulus, update the models, check after the edge.
    task automatic cycle(input bit rst, input bit ld, input int page, input int byt,
                         input bit st, input bit rd, input string tag);
        rst_n = rst; load_en = ld; load_page = 3'(page); load_byte = 8'(byt);
        step_en = st; rd_mode = rd;
        @(posedge clk);
        exp_big   = ref_next(BIG_SEL,   exp_big,   rst, ld, page, byt, st, rd);
        exp_small = ref_next(SMALL_SEL, exp_small, rst, ld, page, byt, st, rd);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED);
        @(negedge clk);
        cycle(0, 0, 0, 0, 0, 0, "R1");
        cycle(0, 1, 7, 8'hAB, 1, 1, "R1");
        // R2/R3: all page bits set, top byte bit set.
        cycle(1, 1, 7, 8'hFF, 0, 0, "R3");
        // R4: write wrap at the page end stays in the page.
        cycle(1, 0, 0, 0, 1, 0, "R4");
        cycle(1, 0, 0, 0, 0, 0, "R6");
        // R5: read rollover from the last location.
        cycle(1, 1, 7, 8'hFF, 0, 0, "R2");
        cycle(1, 0, 0, 0, 1, 1, "R5");
        // R7: load and step together.
        cycle(1, 1, 1, 8'h3C, 1, 1, "R7");
        cycle(1, 1, 2, 8'h45, 1, 0, "R7");
        // R2: page bit used by the larger size.
        cycle(1, 1, 1, 8'h0E, 0, 0, "R2");
        cycle(1, 0, 0, 0, 1, 0, "R4");
        cycle(1, 0, 0, 0, 1, 0, "R4");
        cycle(1, 0, 0, 0, 1, 0, "R4");
        for (int i = 0; i < 400; i++) begin
            bit ld = ($urandom % 8) == 0;
            bit st = ($urandom % 4) != 0;
            bit rd = $urandom % 2;
            int page = $urandom % 8;
            int byt = $urandom % 256;
            string tag;
            if (ld && st) tag = "R7";
            else if (ld) tag = "R2";
            else if (st && rd) tag = "R5";
            else if (st) tag = "R4";
            else tag = "R6";
            cycle(1, ld, page, byt, st, rd, tag);
        end
        cycle(0, 0, 0, 0, 0, 0, "R1");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule